// File: doc/BRIEF.md
# Parallel-Port Register Access Sequencer

This block sits on the host side of a parallel-port link to an IDE disk bridge and performs one register read or register write per request. It drives an 8-bit data bus with its own output enable and a 4-bit control bus, and it watches five status lines. Every access uses the same framing. A three-byte address preamble is wrapped in fixed control-strobe patterns. After it comes either a doubled data write, or a read phase that is strobed four or six times.

Two transfer widths are supported. In nibble mode, writes are full bytes and a read byte is rebuilt from the upper four status lines, sampled twice. In byte mode, the host releases the data bus and samples it directly. Every bus update is held for a step interval set per request, so slow bridges can be paced without changing the sequence.

Top module: `ppi_reg_seq`

## Requirements
- R1: After reset, busy and done are 0, rd_data is 00, pd_out is 00, pd_oe is 1 and pc_out is 4.
- R2: A request is accepted on a clock edge where req_valid is 1 and busy is 0, and busy is 1 from that edge on. While busy is 1, req_valid and the other request inputs have no effect on the sequence. While no access runs, the bus outputs hold their values.
- R3: Each step's bus value is held for step_len+1 cycles. The step_len value is captured when the request is accepted, so changing it later has no effect.
- R4: Every access begins with 19 steps, in this order:
  - data 01, then pattern A;
  - the address byte, then pattern B;
  - data 00, then pattern A.

  Pattern A drives the control values 5, D, 5, D, 5, 4. Pattern B drives 5, 7, 5, 4. The address byte is req_idx*4 + 1 + req_sel.
- R5: A write appends the write byte, then pattern B, then the write byte again, then pattern B, for 29 steps in all.
- R6: A nibble-mode read (byte_mode=0) appends the control values 6, 4, 6, 4, 6, 4, for 25 steps in all. st_in is sampled in the last cycle of the first 6 step (value A) and of the second 6 step (value B). st_in[4:1] carries status lines 7..4. The result is {B[4:1], A[4:1]}.
- R7: A byte-mode read (byte_mode=1) appends the control values 6, 4, 6, 4, for 23 steps in all. pd_oe is 0 during both 6 steps. pd_in is sampled in the last cycle of the first 6 step and becomes the result.
- R8: A data step changes only pd_out. A control step changes only pc_out and pd_oe. pd_oe is 1 in every step except the byte-mode read steps that drive 6.
- R9: done is a one-cycle pulse that rises on the same edge on which busy falls, at the end of the last step. rd_data changes only with done, takes the read result after a read, and keeps its value after a write.
- R10: A new request can be accepted on the edge right after the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = register file, 1 = command set |
| req_idx | input | 3 | Register index |
| req_wdata | input | 8 | Write byte |
| byte_mode | input | 1 | 0 = nibble reads, 1 = byte reads |
| step_len | input | 8 | Extra hold cycles per step |
| busy | output | 1 | Access in progress |
| done | output | 1 | Access complete pulse |
| rd_data | output | 8 | Last read result |
| pd_out | output | 8 | Data bus drive value |
| pd_oe | output | 1 | Data bus drive enable |
| pd_in | input | 8 | Data bus sampled value |
| pc_out | output | 4 | Control bus |
| st_in | input | 5 | Status lines 7..3 |

## Verification
The step 0 output appears on the accept edge, and step i changes at edge i*(step_len+1) after accept. done, the busy drop and rd_data all arrive at edge N*(step_len+1), where N is 29, 25 or 23. The bench waits on that exact edge count from the accept edge and samples 1 ns after each edge. It checks every step at its first cycle and again at each hold cycle, and checks done/rd_data only at the final edge. The bench times the read stimulus by counting the control-6 strobes seen at the port. A sample taken one step early or late therefore yields a different value.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int SEQ_W    = 5;
  localparam int HEAD_LEN = 19;

  typedef enum logic [1:0] {SMP_NONE, SMP_LO, SMP_HI, SMP_BYTE} smp_e;

  typedef struct packed {
    logic       is_ctl;
    logic [7:0] val;
    logic       oe;
    smp_e       smp;
    logic       last;
  } op_t;

  function automatic op_t data_op(input logic [7:0] v);
    op_t o;
    o.is_ctl = 1'b0;
    o.val    = v;
    o.oe     = 1'b1;
    o.smp    = SMP_NONE;
    o.last   = 1'b0;
    return o;
  endfunction

  function automatic op_t ctl_op(input logic [3:0] c, input logic oe);
    op_t o;
    o.is_ctl = 1'b1;
    o.val    = {4'h0, c};
    o.oe     = oe;
    o.smp    = SMP_NONE;
    o.last   = 1'b0;
    return o;
  endfunction

  // six-step strobe: 5 D 5 D 5 4
  function automatic logic [3:0] strobe_a(input logic [SEQ_W-1:0] k);
    if (k == SEQ_W'(5)) return 4'h4;
    else if (k[0])      return 4'hD;
    else                return 4'h5;
  endfunction

  // four-step strobe: 5 7 5 4
  function automatic logic [3:0] strobe_b(input logic [SEQ_W-1:0] k);
    if (k == SEQ_W'(1))      return 4'h7;
    else if (k == SEQ_W'(3)) return 4'h4;
    else                     return 4'h5;
  endfunction
endpackage

// File: rtl/ppi_step_timer.sv
module ppi_step_timer #(
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [STEP_W-1:0] len_in,
  input  logic              run,
  output logic              tick
);
  logic [STEP_W-1:0] len_q;
  logic [STEP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      len_q <= len_in;
      cnt_q <= '0;
    end else if (run) begin
      if (cnt_q == len_q) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == len_q);
endmodule

// File: rtl/ppi_script.sv
module ppi_script
  import ppi_pkg::*;
(
  input  logic [SEQ_W-1:0] pos,
  input  logic             wr,
  input  logic             byte_mode,
  input  logic [7:0]       addr,
  input  logic [7:0]       wdata,
  output op_t              op
);
  logic [SEQ_W-1:0] k;

  always_comb begin
    op = ctl_op(4'h4, 1'b1);
    k  = pos - SEQ_W'(HEAD_LEN);
    if (pos < SEQ_W'(HEAD_LEN)) begin
      if (pos == SEQ_W'(0))       op = data_op(8'h01);
      else if (pos <= SEQ_W'(6))  op = ctl_op(strobe_a(pos - SEQ_W'(1)), 1'b1);
      else if (pos == SEQ_W'(7))  op = data_op(addr);
      else if (pos <= SEQ_W'(11)) op = ctl_op(strobe_b(pos - SEQ_W'(8)), 1'b1);
      else if (pos == SEQ_W'(12)) op = data_op(8'h00);
      else                        op = ctl_op(strobe_a(pos - SEQ_W'(13)), 1'b1);
    end else if (wr) begin
      if (k == SEQ_W'(0) || k == SEQ_W'(5)) op = data_op(wdata);
      else if (k <= SEQ_W'(4))              op = ctl_op(strobe_b(k - SEQ_W'(1)), 1'b1);
      else                                  op = ctl_op(strobe_b(k - SEQ_W'(6)), 1'b1);
      op.last = (k == SEQ_W'(9));
    end else if (byte_mode) begin
      op = ctl_op(k[0] ? 4'h4 : 4'h6, k[0]);
      if (k == SEQ_W'(0)) op.smp = SMP_BYTE;
      op.last = (k == SEQ_W'(3));
    end else begin
      op = ctl_op(k[0] ? 4'h4 : 4'h6, 1'b1);
      if (k == SEQ_W'(0))      op.smp = SMP_LO;
      else if (k == SEQ_W'(2)) op.smp = SMP_HI;
      op.last = (k == SEQ_W'(5));
    end
  end
endmodule

// File: rtl/ppi_read_join.sv
module ppi_read_join #(
  parameter int ST_W = 5,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_lo,
  input  logic            cap_hi,
  input  logic            cap_byte,
  input  logic            byte_mode,
  input  logic [ST_W-1:0] st_in,
  input  logic [DW-1:0]   pd_in,
  output logic [DW-1:0]   result
);
  localparam int NIB = DW / 2;

  logic [NIB-1:0] lo_q, hi_q;
  logic [DW-1:0]  byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      hi_q   <= '0;
      byte_q <= '0;
    end else begin
      if (cap_lo)   lo_q   <= st_in[ST_W-1 -: NIB];
      if (cap_hi)   hi_q   <= st_in[ST_W-1 -: NIB];
      if (cap_byte) byte_q <= pd_in;
    end
  end

  assign result = byte_mode ? byte_q : {hi_q, lo_q};
endmodule

// File: rtl/ppi_reg_seq.sv
module ppi_reg_seq
  import ppi_pkg::*;
#(
  parameter int STEP_W = 8,
  parameter int IDX_W  = 3,
  parameter int ST_W   = 5,
  parameter int DW     = 8,
  parameter int CW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_sel,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DW-1:0]     req_wdata,
  input  logic              byte_mode,
  input  logic [STEP_W-1:0] step_len,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     pd_out,
  output logic              pd_oe,
  input  logic [DW-1:0]     pd_in,
  output logic [CW-1:0]     pc_out,
  input  logic [ST_W-1:0]   st_in
);
  localparam logic [CW-1:0] CTL_IDLE = CW'(4);

  logic             accept, tick;
  logic [SEQ_W-1:0] pos_q, pos_nxt;
  logic             wr_q, mode_q;
  logic [7:0]       addr_q, wdata_q;
  logic [DW-1:0]    joined;
  op_t              op_cur, op_nxt;
  logic             cap_lo, cap_hi, cap_byte;

  assign accept  = req_valid && !busy;
  assign pos_nxt = accept ? '0 : pos_q + 1'b1;

  ppi_step_timer #(.STEP_W(STEP_W)) u_timer (
    .clk(clk), .rst(rst), .load(accept), .len_in(step_len),
    .run(busy), .tick(tick)
  );

  ppi_script u_cur (
    .pos(pos_q), .wr(wr_q), .byte_mode(mode_q),
    .addr(addr_q), .wdata(wdata_q), .op(op_cur)
  );

  ppi_script u_nxt (
    .pos(pos_nxt), .wr(wr_q), .byte_mode(mode_q),
    .addr(addr_q), .wdata(wdata_q), .op(op_nxt)
  );

  assign cap_lo   = tick && (op_cur.smp == SMP_LO);
  assign cap_hi   = tick && (op_cur.smp == SMP_HI);
  assign cap_byte = tick && (op_cur.smp == SMP_BYTE);

  ppi_read_join #(.ST_W(ST_W), .DW(DW)) u_join (
    .clk(clk), .rst(rst), .cap_lo(cap_lo), .cap_hi(cap_hi),
    .cap_byte(cap_byte), .byte_mode(mode_q), .st_in(st_in),
    .pd_in(pd_in), .result(joined)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
      pd_out  <= '0;
      pd_oe   <= 1'b1;
      pc_out  <= CTL_IDLE;
      pos_q   <= '0;
      wr_q    <= 1'b0;
      mode_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        pos_q   <= pos_nxt;
        wr_q    <= req_write;
        mode_q  <= byte_mode;
        addr_q  <= 8'({req_idx, 2'b00}) + 8'd1 + 8'(req_sel);
        wdata_q <= 8'(req_wdata);
        pd_out  <= DW'(op_nxt.val);
        pd_oe   <= op_nxt.oe;
      end else if (tick) begin
        if (op_cur.last) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (!wr_q) rd_data <= joined;
        end else begin
          pos_q <= pos_nxt;
          pd_oe <= op_nxt.oe;
          if (op_nxt.is_ctl) pc_out <= op_nxt.val[CW-1:0];
          else               pd_out <= DW'(op_nxt.val);
        end
      end
    end
  end
endmodule

// File: rtl/ppi_reg_seq_chk.sv
module ppi_reg_seq_chk #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] rd_data,
  input logic          pd_oe,
  input logic [CW-1:0] pc_out
);
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r9_busy_fall_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r2_start_needs_req: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  a_r7_oe_low_only_ctl6: assert property (@(posedge clk) disable iff (rst)
    !pd_oe |-> (pc_out == CW'(6)));

  a_r4_ctl_legal: assert property (@(posedge clk) disable iff (rst)
    (pc_out == CW'(4)) || (pc_out == CW'(5)) || (pc_out == CW'(6)) ||
    (pc_out == CW'(7)) || (pc_out == CW'(13)));

  a_r9_rd_changes_with_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_data) |-> done);

  a_r8_idle_ctl_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(pc_out));
endmodule

bind ppi_reg_seq ppi_reg_seq_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy), .done(done),
  .rd_data(rd_data), .pd_oe(pd_oe), .pc_out(pc_out)
);

// File: tb/sim_ppi_reg_seq.sv
module sim_ppi_reg_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_write = 1'b0, req_sel = 1'b0;
  logic [2:0] req_idx = '0;
  logic [7:0] req_wdata = '0;
  logic       byte_mode = 1'b0;
  logic [7:0] step_len = '0;
  logic       busy, done, pd_oe;
  logic [7:0] rd_data, pd_out, pd_in;
  logic [3:0] pc_out;
  logic [4:0] st_in;

  int checks = 0;
  int fails  = 0;
  int cnt6   = 0;
  logic [3:0] nib_a = '0, nib_b = '0;
  logic       lsb_a = 1'b0, lsb_b = 1'b0;
  logic [7:0] rbyte = '0;
  logic [7:0] exp_rd = '0;

  logic [7:0] e_d [32];
  logic [3:0] e_c [32];
  logic       e_o [32];
  int         en;

  always #10 clk = ~clk;

  assign st_in = (cnt6 <= 1) ? {nib_a, lsb_a} : {nib_b, lsb_b};
  assign pd_in = (cnt6 <= 1) ? rbyte : ~rbyte;

  always @(pc_out) if (pc_out == 4'h6) cnt6 = cnt6 + 1;

  ppi_reg_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .req_idx(req_idx), .req_wdata(req_wdata),
    .byte_mode(byte_mode), .step_len(step_len), .busy(busy), .done(done),
    .rd_data(rd_data), .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in),
    .pc_out(pc_out), .st_in(st_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // expected bus trace, built from the requirement text
  task automatic build(input bit wr, input bit md, input logic [7:0] ad,
                       input logic [7:0] wd);
    logic [3:0] sa [6];
    logic [3:0] sb [4];
    logic [7:0] d;
    logic [3:0] c;
    logic       o;
    sa = '{4'h5, 4'hD, 4'h5, 4'hD, 4'h5, 4'h4};
    sb = '{4'h5, 4'h7, 4'h5, 4'h4};
    en = 0; d = 8'h00; c = 4'h4; o = 1'b1;
    for (int s = 0; s < 3; s++) begin
      d = (s == 0) ? 8'h01 : (s == 1) ? ad : 8'h00;
      e_d[en] = d; e_c[en] = c; e_o[en] = 1'b1; en++;
      if (s == 1) begin
        for (int j = 0; j < 4; j++) begin c = sb[j]; e_d[en] = d; e_c[en] = c; e_o[en] = 1'b1; en++; end
      end else begin
        for (int j = 0; j < 6; j++) begin c = sa[j]; e_d[en] = d; e_c[en] = c; e_o[en] = 1'b1; en++; end
      end
    end
    if (wr) begin
      for (int r = 0; r < 2; r++) begin
        d = wd; e_d[en] = d; e_c[en] = c; e_o[en] = 1'b1; en++;
        for (int j = 0; j < 4; j++) begin c = sb[j]; e_d[en] = d; e_c[en] = c; e_o[en] = 1'b1; en++; end
      end
    end else begin
      for (int j = 0; j < (md ? 4 : 6); j++) begin
        c = (j % 2 == 0) ? 4'h6 : 4'h4;
        o = !(md && c == 4'h6);
        e_d[en] = d; e_c[en] = c; e_o[en] = o; en++;
      end
    end
  endtask

  task automatic access(input bit wr, input bit sel, input logic [2:0] ix,
                        input logic [7:0] wd, input bit md, input int L,
                        input bit poke);
    logic [7:0] ad;
    string tag;
    ad = 8'(int'(ix) * 4 + 1 + int'(sel));
    build(wr, md, ad, wd);
    nib_a = 4'($urandom); nib_b = 4'($urandom); rbyte = 8'($urandom);
    lsb_a = 1'($urandom); lsb_b = 1'($urandom);
    @(negedge clk);
    cnt6 = 0;
    req_valid = 1'b1; req_write = wr; req_sel = sel; req_idx = ix;
    req_wdata = wd; byte_mode = md; step_len = 8'(L);
    @(posedge clk);
    for (int i = 0; i < en; i++) begin
      #1;
      if (i < 19) tag = "R4,R8";
      else if (wr) tag = "R5,R8";
      else if (md) tag = "R7,R8";
      else tag = "R6,R8";
      chk({pd_out, pd_oe, pc_out} == {e_d[i], e_o[i], e_c[i]}, tag,
          {pd_out, pd_oe, pc_out}, {e_d[i], e_o[i], e_c[i]});
      chk(busy == 1'b1, "R2 busy during access", busy, 1);
      if (i == 0) begin
        chk(done == 1'b0, "R9 done low at start", done, 0);
        chk(rd_data == exp_rd, "R10 rd_data held across restart", rd_data, exp_rd);
        req_valid = 1'b0;
        step_len = 8'(L + 3);
      end
      if (poke && i == 2) begin
        req_valid = 1'b1; req_write = ~wr; req_idx = ~ix; req_wdata = ~wd;
        byte_mode = ~md;
      end
      if (poke && i == 3) req_valid = 1'b0;
      for (int h = 0; h < L; h++) begin
        @(posedge clk); #1;
        chk({pd_out, pd_oe, pc_out} == {e_d[i], e_o[i], e_c[i]}, "R3 hold",
            {pd_out, pd_oe, pc_out}, {e_d[i], e_o[i], e_c[i]});
      end
      @(posedge clk);
    end
    #1;
    if (!wr) exp_rd = md ? rbyte : {nib_b, nib_a};
    chk(done == 1'b1, "R9 done at final edge", done, 1);
    chk(busy == 1'b0, "R9 busy falls with done", busy, 0);
    chk(rd_data == exp_rd, wr ? "R9 write keeps rd_data" : (md ? "R7 byte result" : "R6 nibble result"),
        rd_data, exp_rd);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      chk(busy == 1'b0, "R2 idle busy", busy, 0);
      chk(done == 1'b0, "R9 done single pulse", done, 0);
      chk(pc_out == 4'h4, "R2 idle control hold", pc_out, 4);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(posedge clk);
    #1;
    chk({busy, done, rd_data, pd_out, pd_oe, pc_out} == {2'b00, 8'h00, 8'h00, 1'b1, 4'h4},
        "R1 reset state", {busy, done, rd_data, pd_out, pd_oe, pc_out},
        {2'b00, 8'h00, 8'h00, 1'b1, 4'h4});
    @(negedge clk); rst = 1'b0;
    idle(2);
    // directed corners
    access(1'b1, 1'b1, 3'd7, 8'hA5, 1'b0, 0, 1'b0);  // address 1E, no hold
    access(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 2, 1'b1);  // address 01, nibble read, ignored poke
    access(1'b0, 1'b1, 3'd3, 8'h00, 1'b1, 5, 1'b1);  // byte read, long hold
    access(1'b1, 1'b0, 3'd2, 8'h00, 1'b1, 1, 1'b0);  // write of 00 equals preamble tail
    access(1'b0, 1'b0, 3'd5, 8'hFF, 1'b1, 0, 1'b0);  // back-to-back byte read
    idle(1);
    for (int n = 0; n < 40; n++) begin
      access(1'($urandom), 1'($urandom), 3'($urandom), 8'($urandom),
             1'($urandom), int'($urandom % 4), 1'($urandom));
      idle(int'($urandom % 3));
    end
    summary();
    $finish;
  end
endmodule